// File: doc/BRIEF.md
# Block floating-point output normaliser

This block sits behind an FFT engine whose results leave in block floating-point form. Each output word has two parts to its exponent. A group exponent is shared by every word of one transform, and a small tag travels with each word. The normaliser rescales every word to one programmable common exponent, so that everything downstream sees fixed-point data on a single scale.

For each word it forms the full exponent as group exponent plus tag. It subtracts that from the common exponent to get a right-shift count, then shifts the 16-bit signed word arithmetically by that count. Counts above the shifter's range saturate at the maximum shift. A negative count gives no shift and sets a sticky overflow flag.

Complex samples arrive as a real word followed by an imaginary word on one stream. With sharing enabled, the imaginary word reuses the shift worked out for its real partner. Flow control is a valid/ready pair. The latency is a fixed two cycles whenever the sink is ready.

Top module: `bfp_out_norm`

## Requirements
- R1: The full exponent of a word is `in_gexp + in_tag`. The shift is the common exponent minus the full exponent. `out_data` is `in_data` shifted arithmetically right by that shift, with the sign bit copied into the vacated upper bits.
- R2: When the common exponent exceeds the full exponent by more than 15, the word is shifted right by exactly 15 places.
- R3: When the full exponent exceeds the common exponent, the word passes unshifted and `ovf_flag` rises on the next cycle. `ovf_flag` then stays high until it is cleared.
- R4: A high `ovf_clr` at a clock edge drops `ovf_flag` after that edge. If an overflowing word is accepted at the same edge, the flag stays high.
- R5: A high `cexp_we` at a clock edge loads `cexp_wdata` as the common exponent, and words accepted at later edges use it. A word accepted at that same edge still uses the old value. The reset value is 0.
- R6: A word accepted at edge k (`in_valid` and `in_ready` high) appears on `out_data` with `out_valid` high right after edge k+1, provided `out_ready` was high at edge k+1.
- R7: `out_imag` is 0 for real words and 1 for imaginary words. The first word accepted after reset is real, and the phase alternates on every accepted word. Idle cycles do not change the phase.
- R8: With sharing enabled, an imaginary word is shifted by the count computed for the real word just before it. Its own tag and group exponent are ignored, and it never sets `ovf_flag`.
- R9: `in_ready` equals `out_ready`. While `out_ready` is low, no word is accepted and `out_valid`, `out_data` and `out_imag` hold their values.
- R10: After reset, `out_valid` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cexp_we | input | 1 | Write enable for the common exponent |
| cexp_wdata | input | 5 | New common exponent |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 16 | Signed input word |
| in_tag | input | 2 | Per-word exponent tag |
| in_gexp | input | 5 | Per-transform group exponent |
| out_valid | output | 1 | Normalised word present |
| out_ready | input | 1 | Sink accepts the output |
| out_data | output | 16 | Normalised signed word |
| out_imag | output | 1 | 1 when the output word is an imaginary part |
| ovf_flag | output | 1 | Sticky flag for a negative shift count |

## Verification
A word taken at one edge is due on the outputs after the next edge, and a stalled cycle pushes that back by one. The overflow flag and a new common exponent take effect one edge after the stimulus that causes them. The bench keeps a behavioural two-slot model that advances on the same edges and applies the same ready gating. Every output is compared half a period after each edge, so each check lands on the cycle its result is due and never on the edge where it changes.

// File: rtl/bfpn_pkg.sv
package bfpn_pkg;
   // phase of a word inside a complex sample
   typedef enum logic {
      PH_RE = 1'b0,
      PH_IM = 1'b1
   } phase_e;

   // width of an integer expressed in bits needed to hold value v
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((1 << n) <= v) n++;
      return n;
   endfunction
endpackage

// File: rtl/bfpn_exp_calc.sv
module bfpn_exp_calc #(
   parameter int GEXP_W  = 5,
   parameter int TAG_W   = 2,
   parameter int SHIFT_W = 4
) (
   input  logic [GEXP_W-1:0]  gexp,
   input  logic [TAG_W-1:0]   tag,
   input  logic [GEXP_W-1:0]  cexp,
   output logic [SHIFT_W-1:0] shift,
   output logic               neg
);
   localparam int FULL_W = GEXP_W + 1;
   localparam int DIFF_W = FULL_W + 1;
   localparam int MAX_SH = (1 << SHIFT_W) - 1;

   generate
      if (TAG_W > GEXP_W) begin : g_bad_tag
         $error("bfpn_exp_calc: TAG_W must not exceed GEXP_W");
      end
      if (SHIFT_W > FULL_W) begin : g_bad_sh
         $error("bfpn_exp_calc: SHIFT_W too wide for exponent path");
      end
   endgenerate

   logic [FULL_W-1:0]        full_exp;
   logic signed [DIFF_W-1:0] diff;
   logic                     too_big;

   always_comb begin
      full_exp = FULL_W'(gexp) + FULL_W'(tag);
      diff     = $signed({2'b00, cexp}) - $signed({1'b0, full_exp});
      neg      = diff[DIFF_W-1];
      too_big  = !neg && (diff[DIFF_W-2:0] > (DIFF_W-1)'(MAX_SH));
      if (neg)
         shift = '0;
      else if (too_big)
         shift = SHIFT_W'(MAX_SH);
      else
         shift = diff[SHIFT_W-1:0];
   end
endmodule

// File: rtl/bfpn_asr.sv
module bfpn_asr #(
   parameter int DATA_W  = 16,
   parameter int SHIFT_W = 4
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHIFT_W-1:0] amt,
   output logic [DATA_W-1:0]  dout
);
   generate
      if ((1 << SHIFT_W) > DATA_W) begin : g_bad_w
         $error("bfpn_asr: shift range exceeds data width");
      end
   endgenerate

   logic signed [DATA_W-1:0] stg [SHIFT_W+1];

   assign stg[0] = $signed(din);

   // logarithmic shifter: stage s moves by 2**s when its amount bit is set
   for (genvar s = 0; s < SHIFT_W; s++) begin : g_stage
      assign stg[s+1] = amt[s] ? (stg[s] >>> (1 << s)) : stg[s];
   end

   assign dout = stg[SHIFT_W];
endmodule

// File: rtl/bfpn_ctrl.sv
module bfpn_ctrl #(
   parameter int                 GEXP_W   = 5,
   parameter logic [GEXP_W-1:0]  CEXP_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              set_ovf,
   input  logic              ovf_clr,
   input  logic              cexp_we,
   input  logic [GEXP_W-1:0] cexp_wdata,
   output bfpn_pkg::phase_e  phase,
   output logic [GEXP_W-1:0] cexp,
   output logic              ovf
);
   import bfpn_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_RE;
      end else if (accept) begin
         phase <= (phase == PH_RE) ? PH_IM : PH_RE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cexp <= CEXP_RST;
      end else if (cexp_we) begin
         cexp <= cexp_wdata;
      end
   end

   // set takes priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (set_ovf) begin
         ovf <= 1'b1;
      end else if (ovf_clr) begin
         ovf <= 1'b0;
      end
   end

   // R3
   sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !ovf_clr |=> ovf);

   // R4
   clr_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr && !set_ovf |=> !ovf);
endmodule

// File: rtl/bfp_out_norm.sv
module bfp_out_norm #(
   parameter int                DATA_W   = 16,
   parameter int                GEXP_W   = 5,
   parameter int                TAG_W    = 2,
   parameter int                SHIFT_W  = 4,
   parameter bit                SHARE    = 1'b1,
   parameter logic [GEXP_W-1:0] CEXP_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cexp_we,
   input  logic [GEXP_W-1:0] cexp_wdata,
   input  logic              ovf_clr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [GEXP_W-1:0] in_gexp,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_imag,
   output logic              ovf_flag
);
   import bfpn_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_d
         $error("bfp_out_norm: DATA_W too small");
      end
      if (bits_for(DATA_W - 1) < SHIFT_W) begin : g_bad_s
         $error("bfp_out_norm: SHIFT_W too wide for DATA_W");
      end
   endgenerate

   logic               adv;
   logic               accept;
   phase_e             phase;
   logic [GEXP_W-1:0]  cexp;
   logic [SHIFT_W-1:0] calc_sh;
   logic               calc_neg;
   logic [SHIFT_W-1:0] use_sh;
   logic               use_neg;
   logic               s1_v;
   logic [DATA_W-1:0]  s1_d;
   logic [SHIFT_W-1:0] s1_sh;
   logic               s1_im;
   logic [DATA_W-1:0]  asr_q;

   assign adv      = out_ready;
   assign in_ready = out_ready;
   assign accept   = in_valid && adv;

   bfpn_exp_calc #(.GEXP_W(GEXP_W), .TAG_W(TAG_W), .SHIFT_W(SHIFT_W)) u_exp (
      .gexp  (in_gexp),
      .tag   (in_tag),
      .cexp  (cexp),
      .shift (calc_sh),
      .neg   (calc_neg)
   );

   generate
      if (SHARE) begin : g_share
         logic [SHIFT_W-1:0] held_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held_sh <= '0;
            end else if (accept && phase == PH_RE) begin
               held_sh <= calc_sh;
            end
         end
         assign use_sh  = (phase == PH_IM) ? held_sh : calc_sh;
         assign use_neg = (phase == PH_RE) && calc_neg;
      end else begin : g_own
         assign use_sh  = calc_sh;
         assign use_neg = calc_neg;
      end
   endgenerate

   bfpn_ctrl #(.GEXP_W(GEXP_W), .CEXP_RST(CEXP_RST)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .set_ovf    (accept && use_neg),
      .ovf_clr    (ovf_clr),
      .cexp_we    (cexp_we),
      .cexp_wdata (cexp_wdata),
      .phase      (phase),
      .cexp       (cexp),
      .ovf        (ovf_flag)
   );

   // stage 1: capture word and its shift count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         s1_d  <= '0;
         s1_sh <= '0;
         s1_im <= 1'b0;
      end else if (adv) begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_d  <= in_data;
            s1_sh <= use_sh;
            s1_im <= (phase == PH_IM);
         end
      end
   end

   bfpn_asr #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_asr (
      .din  (s1_d),
      .amt  (s1_sh),
      .dout (asr_q)
   );

   // stage 2: register the shifted word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_imag  <= 1'b0;
      end else if (adv) begin
         out_valid <= s1_v;
         if (s1_v) begin
            out_data <= asr_q;
            out_imag <= s1_im;
         end
      end
   end

   // tracker of the last delivered phase, used only by the check below
   logic chk_seen;
   logic chk_last_im;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_seen    <= 1'b0;
         chk_last_im <= 1'b0;
      end else if (out_valid && out_ready) begin
         chk_seen    <= 1'b1;
         chk_last_im <= out_imag;
      end
   end

   // R7
   phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && chk_seen |-> out_imag != chk_last_im);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_imag));

   // R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 out_ready |=> out_valid);
endmodule

// File: tb/tb_bfp_out_norm.sv
module tb_bfp_out_norm;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cexp_we = 1'b0;
   logic [4:0]  cexp_wdata = '0;
   logic        ovf_clr = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic [1:0]  in_tag = '0;
   logic [4:0]  in_gexp = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_data;
   logic        out_imag;
   logic        ovf_flag;

   always #2 clk = ~clk;

   bfp_out_norm dut (
      .clk(clk), .rst_n(rst_n), .cexp_we(cexp_we), .cexp_wdata(cexp_wdata),
      .ovf_clr(ovf_clr), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_tag(in_tag), .in_gexp(in_gexp),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_imag(out_imag), .ovf_flag(ovf_flag)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string in_req = "R1";
   string ovf_req = "R3";

   // behavioural model state
   bit          m_ph;
   int          m_cexp, m_hold;
   bit          m_ovf;
   bit          m1_v, m2_v, m1_im, m2_im;
   logic [15:0] m1_d, m2_d;
   string       m1_req, m2_req;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_cexp = 0; m_hold = 0; m_ovf = 0;
         m1_v = 0; m2_v = 0; m1_im = 0; m2_im = 0; m1_d = 0; m2_d = 0;
      end else begin
         bit set;
         set = 0;
         if (out_ready) begin
            m2_v = m1_v; m2_d = m1_d; m2_im = m1_im; m2_req = m1_req;
            m1_v = in_valid;
            if (in_valid) begin
               int sh;
               if (m_ph == 0) begin
                  int diff;
                  diff = m_cexp - (int'(in_gexp) + int'(in_tag));
                  if (diff < 0) begin sh = 0; set = 1; end
                  else if (diff > 15) sh = 15;
                  else sh = diff;
                  m_hold = sh;
               end else begin
                  sh = m_hold;
               end
               m1_d   = $signed(in_data) >>> sh;
               m1_im  = m_ph;
               m1_req = in_req;
               m_ph   = ~m_ph;
            end
         end
         if (set) m_ovf = 1;
         else if (ovf_clr) m_ovf = 0;
         if (cexp_we) m_cexp = int'(cexp_wdata);
      end
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic tick;
      @(negedge clk);
      chk(out_valid === m2_v, "R6", out_valid, m2_v);
      if (m2_v) begin
         chk(out_data === m2_d, m2_req, out_data, m2_d);
         chk(out_imag === m2_im, "R7", out_imag, m2_im);
      end
      chk(ovf_flag === m_ovf, ovf_req, ovf_flag, m_ovf);
      chk(in_ready === out_ready, "R9", in_ready, out_ready);
   endtask

   task automatic put(input logic [15:0] d, input int t, input int g, input string req);
      in_valid = 1; in_data = d; in_tag = 2'(t); in_gexp = 5'(g); in_req = req;
      tick();
      in_valid = 0;
   endtask

   task automatic set_cexp(input int v);
      cexp_we = 1; cexp_wdata = 5'(v);
      tick();
      cexp_we = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10
      chk(out_valid === 1'b0, "R10", out_valid, 0);
      chk(ovf_flag === 1'b0, "R10", ovf_flag, 0);
      // reset common exponent 0: word passes unshifted (R5)
      put(16'h8123, 0, 0, "R5");
      put(16'h4000, 3, 7, "R8");
      repeat (3) tick();
      // R1: assorted shifts
      set_cexp(20);
      put(16'h7FFF, 1, 10, "R1");
      put(16'h8001, 3, 2, "R8");
      put(16'hC000, 0, 18, "R1");
      put(16'h1234, 2, 1, "R8");
      in_valid = 0; tick();
      // R2: trap to 15
      set_cexp(31);
      put(16'h8000, 0, 0, "R2");
      put(16'h7FFF, 0, 0, "R2");
      put(16'h4000, 0, 15, "R2");
      put(16'hFFFF, 2, 30, "R8");
      // R3: negative count, sticky flag
      set_cexp(10);
      ovf_req = "R3";
      put(16'hA5A5, 3, 12, "R3");
      put(16'h5A5A, 0, 0, "R8");
      repeat (4) tick();
      // R4: clear, then clear together with a new overflow
      ovf_req = "R4";
      ovf_clr = 1; tick(); ovf_clr = 0;
      tick();
      ovf_clr = 1; put(16'h0F0F, 1, 20, "R3"); ovf_clr = 0;
      put(16'h3333, 0, 0, "R8");
      repeat (2) tick();
      ovf_clr = 1; tick(); ovf_clr = 0;
      ovf_req = "R3";
      // R5: write coincident with an accepted word uses old value
      cexp_we = 1; cexp_wdata = 5'd4;
      put(16'h7000, 0, 0, "R5");
      cexp_we = 0;
      put(16'h7000, 0, 0, "R8");
      put(16'h7000, 0, 0, "R5");
      put(16'h7000, 0, 0, "R8");
      // R9: stalls with words in flight
      set_cexp(16);
      in_valid = 1; in_data = 16'h9ABC; in_gexp = 5'd3; in_tag = 2'd1; in_req = "R9";
      tick();
      out_ready = 0; tick(); tick();
      in_data = 16'h1111; tick();
      out_ready = 1; tick();
      in_valid = 0; repeat (3) tick();
      // R7: bubbles do not toggle phase
      put(16'h2222, 0, 8, "R7"); tick(); tick();
      put(16'h3333, 0, 8, "R7"); tick();
      // random traffic
      for (int i = 0; i < 600; i++) begin
         in_valid   = ($urandom_range(0, 3) != 0);
         in_data    = 16'($urandom);
         in_tag     = 2'($urandom);
         in_gexp    = 5'($urandom);
         in_req     = "R1";
         out_ready  = ($urandom_range(0, 4) != 0);
         ovf_clr    = ($urandom_range(0, 15) == 0);
         cexp_we    = ($urandom_range(0, 31) == 0);
         cexp_wdata = 5'($urandom);
         tick();
      end
      in_valid = 0; out_ready = 1; ovf_clr = 0; cexp_we = 0;
      repeat (4) tick();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule